// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

A small 32-bit processor that fetches, decodes, executes and retires one instruction in every clock cycle. It contains a program counter, a 32-entry register file, a word-organised instruction store and a word-organised data store. A main decoder turns the 6-bit major opcode into datapath controls. A second-level ALU decoder combines a 2-bit class from the main decoder with the 6-bit function field to select the ALU operation.

The supported instructions are register-register add, subtract, AND, OR and signed set-less-than; word load; word store; branch-if-equal; and an absolute jump.

Program and data words enter through a preload stream that uses `ld_valid`/`ld_ready`. `ld_ready` is high only while the synchronous reset is held. Software fills both stores during reset. A beat is transferred on a rising edge where both `ld_valid` and `ld_ready` are high. While the core runs, `ld_ready` is low and offered beats are not taken: the source must hold them or drop them. Two combinational peek ports expose one register and one data word, so the contents can be inspected after a program runs.

Top module: `sc_core`

## Requirements
- R1: A rising edge with `rst` high sets the PC to 0 and clears all 32 registers. While `rst` is high, `ld_ready` is 1; otherwise it is 0.
- R2: A preload beat is taken when `ld_valid` and `ld_ready` are both high at a rising edge. The beat writes `ld_data` to word `ld_addr` of the instruction store when `ld_imem`=1, or of the data store when `ld_imem`=0. A beat offered while the core runs changes nothing.
- R3: Major opcode 000000 (bits 31-26) is a register-register operation. It reads registers rs (bits 25-21) and rt (bits 20-16) and writes register rd (bits 15-11). Function field (bits 5-0) 100000 adds, 100010 subtracts (rs-rt), 100100 ANDs, 100101 ORs, and 101010 writes 1 if rs < rt as signed values, otherwise 0.
- R4: Register 0 always reads as 0, and writes to it are dropped.
- R5: Opcode 100011 loads into rt the data word at byte address rs + sign-extended bits 15-0. The word index is that address shifted right by 2.
- R6: Opcode 101011 stores rt to the data word at rs + sign-extended bits 15-0. It writes no register.
- R7: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 + (sign-extended bits 15-0 << 2). Otherwise it is PC+4.
- R8: Opcode 000010 sets the next PC to {bits 31-28 of PC+4, bits 25-0 of the instruction, 2'b00}.
- R9: Every instruction that is not a taken branch or a jump advances the PC by 4. Each instruction completes in one cycle.
- R10: Any other major opcode writes neither a register nor the data store and only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the preload stream |
| ld_valid | input | 1 | Preload beat offered |
| ld_ready | output | 1 | Preload beat can be accepted |
| ld_imem | input | 1 | 1: beat targets instruction store, 0: data store |
| ld_addr | input | 6 | Word index of the preload beat |
| ld_data | input | 32 | Preload word |
| pc | output | 32 | Current program counter |
| peek_reg_sel | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Value of the selected register |
| peek_mem_addr | input | 6 | Data store word index to observe |
| peek_mem_data | output | 32 | Value of the selected data word |

## Verification
Every instruction retires on the rising edge that ends the cycle in which the PC points at it. Register, data-store and PC updates therefore appear exactly one edge after the instruction is fetched. The preload writes land on the edge that accepts the beat.

The bench drives inputs and samples the peek ports at falling edges, so it only reads values that have settled. After reset is released, it waits a fixed number of cycles that is longer than the longest path through the test program before it reads the final state. That final state includes the spin address the PC must settle on. Every operand pair is applied through the same program, and the expected values are computed arithmetically in the bench.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'b00,
    CLS_SUB  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_cls_e;

  typedef enum logic [2:0] {
    AF_AND = 3'b000,
    AF_OR  = 3'b001,
    AF_ADD = 3'b010,
    AF_SUB = 3'b110,
    AF_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_re;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
            mem_re: 1'b0, mem_we: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_ADD};
    unique case (opcode)
      OP_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.cls    = CLS_FUNC;
      end
      OP_LOAD: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.mem_re  = 1'b1;
      end
      OP_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.cls    = CLS_SUB;
      end
      OP_JMP:  ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_cls_e     cls,
  input  logic [5:0]   funct,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  alu_fn_e fn;

  always_comb begin
    unique case (cls)
      CLS_ADD: fn = AF_ADD;
      CLS_SUB: fn = AF_SUB;
      default: begin
        unique case (funct)
          FN_SUB:  fn = AF_SUB;
          FN_AND:  fn = AF_AND;
          FN_OR:   fn = AF_OR;
          FN_SLT:  fn = AF_SLT;
          default: fn = AF_ADD;
        endcase
      end
    endcase
  end

  always_comb begin
    unique case (fn)
      AF_AND:  y = a & b;
      AF_OR:   y = a | b;
      AF_SUB:  y = a - b;
      AF_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // A write to a nonzero register is visible on the next cycle (R3, R5)
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

  // Register 0 never holds anything but zero (R4)
  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> regs[0] == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_imem,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc,
  input  logic [4:0]      peek_reg_sel,
  output logic [XLEN-1:0] peek_reg_data,
  input  logic [DAW-1:0]  peek_mem_addr,
  output logic [XLEN-1:0] peek_mem_data
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] instr, pc4, pc_next, imm_x, br_tgt, j_tgt;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rd, wb_val;
  logic            zero, take_br, ld_go;
  logic [4:0]      wr_reg;
  ctrl_t           c;

  assign ld_ready = rst;
  assign ld_go    = ld_valid && ld_ready;

  // Preload and data store
  always_ff @(posedge clk) begin
    if (ld_go && ld_imem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_go && !ld_imem) dmem[ld_addr[DAW-1:0]] <= ld_data;
    end else if (c.mem_we) begin
      dmem[alu_y[DAW+1:2]] <= rt_val;
    end
  end

  // Fetch
  assign instr = imem[pc[IAW+1:2]];
  assign pc4   = pc + 32'd4;

  sc_decode u_dec (.opcode(instr[31:26]), .ctl(c));

  sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .ra3(peek_reg_sel),
    .rd1(rs_val), .rd2(rt_val), .rd3(peek_reg_data),
    .we(c.reg_we && !rst), .wa(wr_reg), .wd(wb_val)
  );

  assign imm_x = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b = c.src_imm ? imm_x : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .cls(c.cls), .funct(instr[5:0]), .a(rs_val), .b(alu_b),
    .y(alu_y), .zero(zero)
  );

  assign mem_rd = c.mem_re ? dmem[alu_y[DAW+1:2]] : '0;
  assign wb_val = c.wb_mem ? mem_rd : alu_y;
  assign wr_reg = c.dst_rd ? instr[15:11] : instr[20:16];

  // Next PC
  assign br_tgt  = pc4 + {imm_x[XLEN-3:0], 2'b00};
  assign j_tgt   = {pc4[31:28], instr[25:0], 2'b00};
  assign take_br = c.branch && zero;

  always_comb begin
    if (c.jump)       pc_next = j_tgt;
    else if (take_br) pc_next = br_tgt;
    else              pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign peek_mem_data = dmem[peek_mem_addr];

  // Reset returns fetch to address 0 (R1)
  assert_pc_reset_R1: assert property (@(posedge clk)
    rst |=> pc == '0);

  // Plain sequencing advances by one word (R9)
  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!c.branch && !c.jump) |=> pc == $past(pc) + 32'd4);

  // An unequal compare falls through (R7)
  assert_br_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (c.branch && !zero) |=> pc == $past(pc) + 32'd4);

  // A taken branch only happens on equal operands (R7)
  assert_br_equal_R7: assert property (@(posedge clk) disable iff (rst)
    (c.branch && zero) |-> rs_val == rt_val);

  // A store never writes a register (R6)
  assert_store_noreg_R6: assert property (@(posedge clk) disable iff (rst)
    c.mem_we |-> !c.reg_we);

  // At most one memory or flow action per instruction (R10)
  assert_ctrl_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({c.mem_re, c.mem_we, c.branch, c.jump}));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR      = 12;
  localparam int RUN_CYC    = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_imem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc;
  logic [4:0]  peek_reg_sel = '0;
  logic [31:0] peek_reg_data;
  logic [5:0]  peek_mem_addr = '0;
  logic [31:0] peek_mem_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_imem(ld_imem), .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc),
    .peek_reg_sel(peek_reg_sel), .peek_reg_data(peek_reg_data),
    .peek_mem_addr(peek_mem_addr), .peek_mem_data(peek_mem_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'b000010, idx};
  endfunction

  function automatic logic [31:0] prog(int k);
    case (k)
      0:  return enc_i(6'b100011, 0, 1, 16'd0);      // load r1 <- word 0
      1:  return enc_i(6'b100011, 0, 2, 16'd4);      // load r2 <- word 1
      2:  return enc_r(1, 2, 3, 6'b100000);          // add
      3:  return enc_r(1, 2, 4, 6'b100010);          // sub
      4:  return enc_r(1, 2, 5, 6'b100100);          // and
      5:  return enc_r(1, 2, 6, 6'b100101);          // or
      6:  return enc_r(1, 2, 7, 6'b101010);          // slt
      7:  return enc_i(6'b101011, 0, 3, 16'd8);      // store r3 -> word 2
      8:  return enc_r(1, 2, 0, 6'b100000);          // write to r0
      9:  return enc_i(6'b000100, 1, 2, 16'd2);      // beq -> word 12
      10: return enc_r(1, 1, 8, 6'b100000);          // fall-through only
      11: return enc_j(26'd13);
      12: return enc_r(2, 2, 9, 6'b100000);          // taken path only
      13: return {6'b111111, 5'd1, 5'd10, 5'd10, 11'd0}; // undefined opcode
      14: return enc_j(26'd14);                      // spin
      15: return enc_i(6'b101011, 11, 4, 16'hFFF8);  // never reached
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_word(bit im, int addr, logic [31:0] d);
    ld_valid = 1'b1; ld_imem = im; ld_addr = addr[5:0]; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic reg_is(string req, int r, logic [31:0] exp);
    peek_reg_sel = r[4:0];
    #1;
    chk(req, peek_reg_data, exp);
  endtask

  task automatic mem_is(string req, int a, logic [31:0] exp);
    peek_mem_addr = a[5:0];
    #1;
    chk(req, peek_mem_data, exp);
  endtask

  function automatic logic [31:0] opa(int p);
    case (p)
      0: return 32'd5;          1: return 32'd3;
      2: return 32'd7;          3: return 32'hFFFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'h7FFF_FFFF;
      6: return 32'd0;          7: return 32'hAAAA_5555;
      default: return 32'h0137_9BDF * p[31:0] + 32'h1111;
    endcase
  endfunction
  function automatic logic [31:0] opb(int p);
    case (p)
      0: return 32'd3;          1: return 32'd5;
      2: return 32'd7;          3: return 32'd1;
      4: return 32'd1;          5: return 32'hFFFF_FFFF;
      6: return 32'd0;          7: return 32'h5555_AAAA;
      8: return 32'h0137_9BDF * 8 + 32'h1111;  // equal pair
      default: return 32'hFEDC_1234 ^ (p[31:0] << 7);
    endcase
  endfunction

  initial begin
    logic [31:0] a, b;
    @(negedge clk);
    for (int p = 0; p < NPAIR; p++) begin
      a = opa(p);
      b = opb(p);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 pc in reset", pc, 32'h0);
      chk("R1 ready in reset", {31'd0, ld_ready}, 32'd1);
      reg_is("R1 regs cleared", 3, 32'h0);
      for (int k = 0; k < 16; k++) load_word(1'b1, k, prog(k));
      load_word(1'b0, 0, a);
      load_word(1'b0, 1, b);
      for (int k = 2; k < 6; k++) load_word(1'b0, k, 32'h0);
      mem_is("R2 preload data", 1, b);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready while running", {31'd0, ld_ready}, 32'd0);
      chk("R9 first step", pc, 32'd4);
      load_word(1'b0, 5, 32'hDEAD_BEEF);   // must be refused
      for (int c = 0; c < RUN_CYC; c++) @(negedge clk);

      reg_is("R5 load r1", 1, a);
      reg_is("R5 load r2", 2, b);
      reg_is("R3 add + R6 no reg write", 3, a + b);
      reg_is("R3 sub", 4, a - b);
      reg_is("R3 and", 5, a & b);
      reg_is("R3 or", 6, a | b);
      reg_is("R3 slt", 7, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
      reg_is("R4 r0 zero", 0, 32'h0);
      reg_is("R7 fall-through path", 8, (a == b) ? 32'h0 : a + a);
      reg_is("R7 taken path", 9, (a == b) ? b + b : 32'h0);
      reg_is("R10 undefined opcode", 10, 32'h0);
      mem_is("R6 store", 2, a + b);
      mem_is("R10 no store", 3, 32'h0);
      mem_is("R2 refused beat", 5, 32'h0);
      chk("R8 jump spin", pc, 32'd56);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule